// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block models the host-facing command interface of a byte-wide flash array split into equal, separately erasable blocks. A host writes command bytes, addresses and data through an asynchronous-style write strobe. The block decodes them into a read mode (array contents, status byte or identifier bytes), and it runs timed byte-program and block-erase jobs against a behavioural storage array. A busy/ready pin and a status byte report progress.

A running erase can be parked so that the host can read other blocks or program bytes outside the parked block. A running byte program can also be parked, and while it is parked the host may only read. A power-down input holds the whole sequencer in reset, blocks every write and hands control back in array-read mode. Job lengths are set by parameters. Programming cycles are counted, and an erase visits one byte per clock.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, or when `dpd_n` returns high, the read mode is array, `ry_by` is high and the status byte reads 0x80.
- R2: While `dpd_n` is low, `ry_by` is high, no write strobe has any effect on the array or the mode, and both error flags are cleared.
- R3: A command is taken only on a low-to-high transition of `bus_we_n`, using the address and data present in the cycle where the strobe is high again. A long low phase yields a single command.
- R4: Command 0xFF selects array reads, 0x70 selects status reads and 0x90 selects identifier reads. In identifier mode, an even address returns `ID_MAKER` and an odd address returns `ID_DEVICE`. The mode holds until it is changed.
- R5: Command 0x40 followed by an address/data write programs that byte to old AND new. `ry_by` stays low for exactly `WRITE_CYCLES` cycles, and afterwards the read mode is status.
- R6: Command 0x20 followed by 0xD0 sets every byte of the addressed block (block index = upper address bits) to 0xFF and leaves the other blocks unchanged. `ry_by` stays low for exactly `BLK_BYTES` cycles.
- R7: If the write after 0x20 is anything other than 0xD0, status bits 5 and 4 are set, nothing is erased and the sequencer returns to idle.
- R8: Command 0xB0 during an erase parks it. `ry_by` goes high, status bit 6 is set and reads from other blocks work. 0xD0 resumes the erase, which then finishes with fewer than `BLK_BYTES` busy cycles.
- R9: While an erase is parked, a byte program to another block runs normally and status bit 6 stays set. A program aimed at the parked block sets status bit 4 and changes nothing.
- R10: Command 0xB0 during a byte program parks it. `ry_by` goes high and status bit 2 is set. Array reads work, and a new 0x40 is ignored. 0xD0 resumes the program and completes it.
- R11: Status bit 7 is high exactly when no job is running. Command 0x50 clears bits 5 and 4. Bit 3 and bits 1:0 are always zero.
- R12: A command that does not apply in the current state (for example 0xD0 or 0xB0 while idle) changes neither the array, the status nor the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dpd_n | input | 1 | Active-low power-down; holds the sequencer in reset |
| bus_we_n | input | 1 | Active-low write strobe; its rising edge takes a command |
| bus_addr | input | AW | Byte address (read address and write address) |
| bus_wdata | input | 8 | Command or program data |
| bus_rdata | output | 8 | Array byte, status byte or identifier byte, depending on read mode |
| ry_by | output | 1 | High when no job is running (idle, parked or powered down) |

## Verification
The assertions take three things for granted about the inputs. `bus_we_n` is sampled once per clock. An erase job is never started again while its byte walk is still under way. Power-down only has to act within one clock, not combinationally. The stimulus drives every strobe at least two clocks apart and always sets the address and data in the same cycle that the strobe rises. It issues suspend commands early enough that a job is still running when the command arrives, so the case where a suspend and job completion fall on the same clock never occurs in the checks.

// File: rtl/fcs_pkg.sv
// Package: command byte values, read modes and sequencer states shared by
// the flash command sequencer modules. Assumes byte-wide commands.
package fcs_pkg;
    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_WR_SETUP  = 8'h40;
    localparam logic [7:0] CMD_ER_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_IDENT
    } rmode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_ESETUP,
        ST_WBUSY,
        ST_EBUSY,
        ST_WSUSP,
        ST_ESUSP
    } seq_t;
endpackage

// File: rtl/fcs_strobe.sv
// Module: fcs_strobe
// Detects the low-to-high transition of the write strobe and registers the
// address and data seen in that cycle as a one-cycle command pulse.
// Assumes the strobe is already synchronous to clk. Held cleared while in
// reset or power-down, so that leaving either state cannot fake an edge.
module fcs_strobe #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          cmd_vld,
    output logic [AW-1:0] cmd_addr,
    output logic [7:0]    cmd_data
);
    logic we_q;
    logic edge_hit;

    // Rising edge of the strobe, as seen at this clock.
    assign edge_hit = !we_q && we_n;

    // Remember the strobe level and capture the command on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            we_q     <= 1'b1;
            cmd_vld  <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            we_q    <= we_n;
            cmd_vld <= edge_hit;
            if (edge_hit) begin
                cmd_addr <= addr;
                cmd_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/fcs_array.sv
// Module: fcs_array
// Behavioural byte storage. A program port ANDs the new byte into the
// stored one, and an erase port forces one byte to 0xFF. Reads are
// combinational. Assumes the two ports are never used in the same cycle
// (program wins if they are). The contents have no reset, like real storage.
module fcs_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          er_en,
    input  logic [AW-1:0] er_addr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Apply one program (bit clearing) or one erase step per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end else if (er_en) begin
            mem[er_addr] <= 8'hFF;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fcs_wsm.sv
// Module: fcs_wsm
// Command decoder and job sequencer. It tracks the read mode, runs timed
// byte programs and one-byte-per-clock block erases, and handles erase
// suspend with nested programs and program suspend. It also builds the
// status byte. Assumes at most one command pulse per cycle. Power-down acts
// as a synchronous reset of all state.
module fcs_wsm
    import fcs_pkg::*;
#(
    parameter int BLK_W        = 4,
    parameter int OFF_W        = 6,
    parameter int WRITE_CYCLES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dpd_n,
    input  logic                   cmd_vld,
    input  logic [BLK_W+OFF_W-1:0] cmd_addr,
    input  logic [7:0]             cmd_data,
    output rmode_t                 rmode,
    output logic [7:0]             status,
    output logic                   busy,
    output logic                   arr_wr_en,
    output logic [BLK_W+OFF_W-1:0] arr_wr_addr,
    output logic [7:0]             arr_wr_data,
    output logic                   arr_er_en,
    output logic [BLK_W+OFF_W-1:0] arr_er_addr
);
    localparam int              AW       = BLK_W + OFF_W;
    localparam int              CW       = $clog2(WRITE_CYCLES + 1);
    localparam logic [OFF_W-1:0] OFF_LAST = '1;

    seq_t             st;
    logic             err_er;
    logic             err_wr;
    logic             er_held;
    logic [BLK_W-1:0] er_blk;
    logic [OFF_W-1:0] er_ptr;
    logic [AW-1:0]    wr_addr_q;
    logic [7:0]       wr_data_q;
    logic [CW-1:0]    wcnt;
    logic             susp_req;
    logic             mode_ok;
    logic             same_blk;

    // Decode helpers shared by the job and mode logic.
    always_comb begin
        susp_req = cmd_vld && (cmd_data == CMD_SUSPEND);
        mode_ok  = (st == ST_IDLE) || (st == ST_ESUSP) || (st == ST_WSUSP);
        same_blk = er_held && (cmd_addr[AW-1:OFF_W] == er_blk);
        busy     = (st == ST_WBUSY) || (st == ST_EBUSY);
    end

    // Array strobes: the program commits on its last count, and erase steps
    // run while no suspend arrives.
    always_comb begin
        arr_wr_en   = (st == ST_WBUSY) && (wcnt == '0) && !susp_req;
        arr_wr_addr = wr_addr_q;
        arr_wr_data = wr_data_q;
        arr_er_en   = (st == ST_EBUSY) && !susp_req;
        arr_er_addr = {er_blk, er_ptr};
    end

    // Status byte: ready, erase parked, erase error, program error, program parked.
    assign status = {!busy, er_held, err_er, err_wr, 1'b0, (st == ST_WSUSP), 2'b00};

    // Job sequencing, error flags and read mode selection.
    always_ff @(posedge clk) begin
        if (!rst_n || !dpd_n) begin
            st        <= ST_IDLE;
            rmode     <= RM_ARRAY;
            err_er    <= 1'b0;
            err_wr    <= 1'b0;
            er_held   <= 1'b0;
            er_blk    <= '0;
            er_ptr    <= '0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            wcnt      <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cmd_vld && cmd_data == CMD_WR_SETUP) begin
                        st    <= ST_WSETUP;
                        rmode <= RM_STATUS;
                    end else if (cmd_vld && cmd_data == CMD_ER_SETUP) begin
                        st    <= ST_ESETUP;
                        rmode <= RM_STATUS;
                    end
                end
                ST_ESUSP: begin
                    if (cmd_vld && cmd_data == CMD_WR_SETUP) begin
                        st    <= ST_WSETUP;
                        rmode <= RM_STATUS;
                    end else if (cmd_vld && cmd_data == CMD_CONFIRM) begin
                        st      <= ST_EBUSY;
                        er_held <= 1'b0;
                    end
                end
                ST_WSETUP: begin
                    if (cmd_vld) begin
                        if (same_blk) begin
                            err_wr <= 1'b1;
                            st     <= ST_ESUSP;
                        end else begin
                            wr_addr_q <= cmd_addr;
                            wr_data_q <= cmd_data;
                            wcnt      <= CW'(WRITE_CYCLES - 1);
                            st        <= ST_WBUSY;
                        end
                    end
                end
                ST_ESETUP: begin
                    if (cmd_vld) begin
                        if (cmd_data == CMD_CONFIRM) begin
                            er_blk <= cmd_addr[AW-1:OFF_W];
                            er_ptr <= '0;
                            st     <= ST_EBUSY;
                        end else begin
                            err_er <= 1'b1;
                            err_wr <= 1'b1;
                            st     <= ST_IDLE;
                        end
                    end
                end
                ST_WBUSY: begin
                    if (susp_req) begin
                        st <= ST_WSUSP;
                    end else if (wcnt == '0) begin
                        st <= er_held ? ST_ESUSP : ST_IDLE;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                ST_EBUSY: begin
                    if (susp_req) begin
                        st      <= ST_ESUSP;
                        er_held <= 1'b1;
                    end else if (er_ptr == OFF_LAST) begin
                        st <= ST_IDLE;
                    end else begin
                        er_ptr <= er_ptr + 1'b1;
                    end
                end
                ST_WSUSP: begin
                    if (cmd_vld && cmd_data == CMD_CONFIRM) begin
                        st <= ST_WBUSY;
                    end
                end
                default: st <= ST_IDLE;
            endcase

            if (cmd_vld && mode_ok) begin
                case (cmd_data)
                    CMD_RD_ARRAY:  rmode <= RM_ARRAY;
                    CMD_RD_STATUS: rmode <= RM_STATUS;
                    CMD_RD_IDENT:  rmode <= RM_IDENT;
                    CMD_CLR_STAT: begin
                        err_er <= 1'b0;
                        err_wr <= 1'b0;
                    end
                    default: ;
                endcase
            end else if (cmd_vld && busy && cmd_data == CMD_RD_STATUS) begin
                rmode <= RM_STATUS;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Module: flash_cmd_seq
// Top of the flash command sequencer. Joins the strobe capture, the job
// sequencer and the storage array, and selects the read data by read mode.
// Assumes BLK_CNT and BLK_BYTES are powers of two.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int         BLK_CNT      = 16,
    parameter int         BLK_BYTES    = 64,
    parameter int         WRITE_CYCLES = 8,
    parameter logic [7:0] ID_MAKER     = 8'h5A,
    parameter logic [7:0] ID_DEVICE    = 8'hA6,
    localparam int        BLK_W        = $clog2(BLK_CNT),
    localparam int        OFF_W        = $clog2(BLK_BYTES),
    localparam int        AW           = BLK_W + OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dpd_n,
    input  logic          bus_we_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          ry_by
);
    logic          cmd_vld;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;
    rmode_t        rmode;
    logic [7:0]    status;
    logic          busy;
    logic          arr_wr_en;
    logic [AW-1:0] arr_wr_addr;
    logic [7:0]    arr_wr_data;
    logic          arr_er_en;
    logic [AW-1:0] arr_er_addr;
    logic [7:0]    arr_rd_data;

    fcs_strobe #(.AW(AW)) strobe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (dpd_n),
        .we_n     (bus_we_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cmd_vld  (cmd_vld),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data)
    );

    fcs_wsm #(
        .BLK_W        (BLK_W),
        .OFF_W        (OFF_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) wsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dpd_n       (dpd_n),
        .cmd_vld     (cmd_vld),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .rmode       (rmode),
        .status      (status),
        .busy        (busy),
        .arr_wr_en   (arr_wr_en),
        .arr_wr_addr (arr_wr_addr),
        .arr_wr_data (arr_wr_data),
        .arr_er_en   (arr_er_en),
        .arr_er_addr (arr_er_addr)
    );

    fcs_array #(.AW(AW)) array_i (
        .clk     (clk),
        .wr_en   (arr_wr_en),
        .wr_addr (arr_wr_addr),
        .wr_data (arr_wr_data),
        .er_en   (arr_er_en),
        .er_addr (arr_er_addr),
        .rd_addr (bus_addr),
        .rd_data (arr_rd_data)
    );

    // Read data selection by the current read mode.
    always_comb begin
        case (rmode)
            RM_STATUS: bus_rdata = status;
            RM_IDENT:  bus_rdata = bus_addr[0] ? ID_DEVICE : ID_MAKER;
            default:   bus_rdata = arr_rd_data;
        endcase
    end

    assign ry_by = !busy;
endmodule

// File: rtl/fcs_checker.sv
// Module: fcs_checker
// Temporal checks on the flash command sequencer, attached by bind.
// Assumes reset is synchronous and active low.
module fcs_checker #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dpd_n,
    input logic          we_n,
    input logic          ry_by,
    input logic          cmd_vld,
    input logic          wr_en,
    input logic          er_en,
    input logic [AW-1:0] er_addr,
    input logic [7:0]    status
);
    // R2: one clock into power-down, the pin reports ready.
    assert_dpd_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dpd_n |=> ry_by);

    // R2: one clock into power-down, the array is not touched.
    assert_dpd_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dpd_n |=> (!wr_en && !er_en));

    // R3: a command pulse follows a low-then-high strobe.
    assert_edge_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> ($past(we_n) && !$past(we_n, 2)));

    // R5: program and erase never hit the array in the same cycle.
    assert_one_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && er_en));

    // R6: consecutive erase steps walk upward by one byte.
    assert_erase_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (er_en && $past(er_en)) |-> (er_addr == AW'($past(er_addr) + 1'b1)));

    // R10: entering program suspend leaves the pin ready.
    assert_wsusp_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> ry_by);
endmodule

bind flash_cmd_seq fcs_checker #(.AW(AW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .dpd_n   (dpd_n),
    .we_n    (bus_we_n),
    .ry_by   (ry_by),
    .cmd_vld (cmd_vld),
    .wr_en   (arr_wr_en),
    .er_en   (arr_er_en),
    .er_addr (arr_er_addr),
    .status  (status)
);

// File: tb/flash_cmd_seq_tb_top.sv
// Bench: sweeps every block and every byte of the default configuration,
// keeping its own model of the array, and checks modes, timing and suspends.
module flash_cmd_seq_tb_top;
    localparam int AW    = 10;
    localparam int NB    = 1 << AW;
    localparam int BB    = 64;
    localparam int WCYC  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dpd_n = 1'b1;
    logic          bus_we_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          ry_by;

    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;
    logic [7:0] model [NB];

    always #10 clk = !clk;

    flash_cmd_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dpd_n     (dpd_n),
        .bus_we_n  (bus_we_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ry_by     (ry_by)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Strobe low with wrong values, then high with the real ones.
    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        bus_we_n  = 1'b0;
        bus_addr  = ~AW'(a);
        bus_wdata = ~8'(d);
        @(negedge clk);
        bus_we_n  = 1'b1;
        bus_addr  = AW'(a);
        bus_wdata = 8'(d);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = AW'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        int v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (ry_by == 1'b0 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sweep(input string req);
        bus_wr(0, 8'hFF);
        for (int a = 0; a < NB; a++) rd_chk(req, a, int'(model[a]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int a;
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ready after reset", int'(ry_by), 1);
        bus_wr(0, 8'h70);
        rd_chk("R1 status after reset", 0, 8'h80);

        // R6: erase every block, offset bits in the address are ignored
        for (int b = 0; b < 16; b++) begin
            bus_wr(b * BB + b, 8'h20);
            bus_wr(b * BB + b, 8'hD0);
            busy_len(n);
            check("R6 erase busy length", n, BB);
        end
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        sweep("R6 erased contents");

        // R5: program a pattern into every block, timing and read mode
        for (int b = 0; b < 16; b++) begin
            for (int k = 0; k < 4; k++) begin
                a = b * BB + ((k * 13 + b) % BB);
                d = ((b * 37 + k * 11) ^ 8'h3C) & 8'hFF;
                bus_wr(a, 8'h40);
                bus_wr(a, d);
                busy_len(n);
                check("R5 program busy length", n, WCYC);
                rd_chk("R5 status mode after program", 0, 8'h80);
                model[a] = model[a] & 8'(d);
            end
        end
        // R5: second program ANDs into the stored byte
        for (int b = 0; b < 16; b++) begin
            a = b * BB + b;
            d = (8'h0F ^ (b * 17)) & 8'hFF;
            bus_wr(a, 8'h40);
            bus_wr(a, d);
            busy_len(n);
            model[a] = model[a] & 8'(d);
        end
        sweep("R5 programmed contents");

        // R4: read modes
        bus_wr(0, 8'h90);
        rd_chk("R4 ident even", 0, 8'h5A);
        rd_chk("R4 ident odd", 1, 8'hA6);
        rd_chk("R4 ident even high", 130, 8'h5A);
        bus_wr(0, 8'h70);
        rd_chk("R4 status mode", 5, 8'h80);
        bus_wr(0, 8'hFF);
        rd_chk("R4 array mode", 5, int'(model[5]));

        // R12: confirm and suspend while idle do nothing
        bus_wr(5, 8'hD0);
        bus_wr(5, 8'hB0);
        check("R12 ready stays high", int'(ry_by), 1);
        rd_chk("R12 array mode kept", 5, int'(model[5]));
        bus_wr(0, 8'h70);
        rd_chk("R12 status unchanged", 0, 8'h80);

        // R7: bad erase confirm
        bus_wr(2 * BB, 8'h20);
        bus_wr(2 * BB, 8'h00);
        rd_chk("R7 error bits", 0, 8'hB0);
        bus_wr(0, 8'hFF);
        rd_chk("R7 block not erased", 2 * BB + 2, int'(model[2 * BB + 2]));

        // R11: clear status
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h70);
        rd_chk("R11 errors cleared", 0, 8'h80);

        // R2: power-down blocks writes and clears errors
        bus_wr(2 * BB, 8'h20);
        bus_wr(2 * BB, 8'h00);
        rd_chk("R2 errors before power-down", 0, 8'hB0);
        @(negedge clk);
        dpd_n = 1'b0;
        @(negedge clk);
        check("R2 ready in power-down", int'(ry_by), 1);
        bus_wr(9 * BB + 1, 8'h40);
        bus_wr(9 * BB + 1, 8'h00);
        bus_wr(9 * BB, 8'h20);
        bus_wr(9 * BB, 8'hD0);
        check("R2 ready after writes in power-down", int'(ry_by), 1);
        dpd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R1 array mode after power-down", 9 * BB + 1, int'(model[9 * BB + 1]));
        rd_chk("R2 block untouched", 9 * BB + 9, int'(model[9 * BB + 9]));
        bus_wr(0, 8'h70);
        rd_chk("R2 status cleared", 0, 8'h80);

        // R8: suspend an erase
        bus_wr(3 * BB, 8'h20);
        bus_wr(3 * BB, 8'hD0);
        repeat (10) @(negedge clk);
        bus_wr(0, 8'hB0);
        check("R8 ready while erase parked", int'(ry_by), 1);
        rd_chk("R8 status erase parked", 0, 8'hC0);
        bus_wr(0, 8'hFF);
        rd_chk("R8 read other block", 4 * BB + 4, int'(model[4 * BB + 4]));
        // R9: nested program into another block
        a = 5 * BB + 7;
        bus_wr(a, 8'h40);
        bus_wr(a, 8'h3C);
        busy_len(n);
        check("R9 nested program busy length", n, WCYC);
        model[a] = model[a] & 8'h3C;
        rd_chk("R9 status after nested program", 0, 8'hC0);
        // R9: program into the parked block is refused
        bus_wr(3 * BB + 60, 8'h40);
        bus_wr(3 * BB + 60, 8'h00);
        rd_chk("R9 refused program error", 0, 8'hD0);
        check("R9 ready after refused program", int'(ry_by), 1);
        bus_wr(0, 8'hFF);
        rd_chk("R9 parked block byte kept", 3 * BB + 60, int'(model[3 * BB + 60]));
        rd_chk("R9 nested program value", a, int'(model[a]));
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h70);
        rd_chk("R11 clear keeps parked bit", 0, 8'hC0);
        // R8: resume the erase
        bus_wr(0, 8'hD0);
        busy_len(n);
        check("R8 resumed erase shorter", int'(n > 0 && n < BB), 1);
        for (int i = 0; i < BB; i++) model[3 * BB + i] = 8'hFF;
        rd_chk("R8 status after resume", 0, 8'h80);

        // R10: suspend a program
        a = 6 * BB + 20;
        bus_wr(a, 8'h40);
        bus_wr(a, 8'h55);
        bus_wr(0, 8'hB0);
        check("R10 ready while program parked", int'(ry_by), 1);
        rd_chk("R10 status program parked", 0, 8'h84);
        bus_wr(0, 8'hFF);
        rd_chk("R10 target not yet programmed", a, int'(model[a]));
        rd_chk("R10 read other location", 7 * BB + 3, int'(model[7 * BB + 3]));
        bus_wr(7 * BB + 3, 8'h40);
        bus_wr(7 * BB + 3, 8'h00);
        rd_chk("R10 new program ignored", 7 * BB + 3, int'(model[7 * BB + 3]));
        check("R10 still ready", int'(ry_by), 1);
        bus_wr(0, 8'hD0);
        busy_len(n);
        check("R10 resumed program runs", int'(n > 0 && n < WCYC), 1);
        model[a] = model[a] & 8'h55;
        rd_chk("R10 program completed", a, int'(model[a]));
        bus_wr(0, 8'h70);
        rd_chk("R11 ready bit after resume", 0, 8'h80);

        // R3: long strobe low phase gives one command
        a = 8 * BB + 33;
        @(negedge clk);
        bus_we_n  = 1'b0;
        bus_wdata = 8'h20;
        repeat (5) @(negedge clk);
        bus_we_n  = 1'b1;
        bus_addr  = AW'(a);
        bus_wdata = 8'h40;
        @(negedge clk);
        @(negedge clk);
        bus_wr(a, 8'h0F);
        busy_len(n);
        check("R3 single program from long strobe", n, WCYC);
        model[a] = model[a] & 8'h0F;
        bus_wr(8 * BB + 40, 8'h00);
        check("R3 data byte not reused as command", int'(ry_by), 1);

        sweep("R3 final contents");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule